// File: doc/BRIEF.md
# GHASH Field Multiply Unit

This block does the arithmetic of the GHASH authentication function in Galois Counter Mode. Each 128-bit operand arrives as four 32-bit elements. Element k sits in bits `[32k+31:32k]` of its port, and together the four elements form one element of GF(2^128). The block has two operations. The plain multiply returns `prev_hash · hash_key`. The accumulate-multiply first folds a ciphertext block into the running hash and then multiplies the sum by the hash key: `(prev_hash XOR cipher_blk) · hash_key`. This is the XOR-then-multiply step that GCM software runs once per block, so a driver loop needs one operation per ciphertext block.

The multiply is bit-serial. It takes one multiplier bit per clock, and every operation lasts the same number of cycles whatever the data, so the timing reveals nothing about the key or the text. The operands are captured on an accepted `start`. `done` then pulses once, and `result` holds the reduced product until the next operation completes. Every accepted operation is processed: there is no masking or skipping of element groups. Deriving the hash key, building length blocks and finalising the tag are left to the surrounding logic.

Top module: `ghash_mul_unit`

## Requirements
- R1: After reset `done` is 0 and `result` is all zeros.
- R2: With `accumulate`=0 the result is `prev_hash · hash_key`, and `cipher_blk` has no effect.
- R3: With `accumulate`=1 the result is `(prev_hash XOR cipher_blk) · hash_key`.
- R4: Field bit order and reduction: port bit 127 is the x^0 coefficient and bit 0 is the x^127 coefficient. Products are reduced modulo x^128 + x^7 + x^2 + x + 1. So x^1 (bit 126 set) times x^127 (bit 0 set) gives `E1` followed by 30 zero hex digits. Multiplying by x^0 (only bit 127 set) returns the other operand unchanged.
- R5: `done` rises exactly 128 clock cycles after the edge that accepts `start`, for every operand value.
- R6: `done` is high for exactly one cycle. `result` changes only on the edge that raises `done` and holds otherwise.
- R7: A `start` that arrives while an operation is in progress is ignored. It neither restarts nor alters the running operation.
- R8: The operands are captured when `start` is accepted. Changing `prev_hash`, `cipher_blk`, `hash_key` or `accumulate` afterwards does not change that result.
- R9: A zero hash key or a zero multiplier gives an all-zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when the unit is idle |
| accumulate | input | 1 | 1 selects XOR-then-multiply, 0 selects plain multiply |
| prev_hash | input | 128 | Previous hash or plain operand (four 32-bit elements) |
| cipher_blk | input | 128 | Ciphertext block folded in when `accumulate`=1 |
| hash_key | input | 128 | Hash key H |
| result | output | 128 | Reduced product, held between operations |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
If the iteration counter is corrupted, `done` appears early, late or twice, and the scoreboard's due-cycle comparison catches it at the first operation. A fault in the reduction step or the bit order gives a wrong product as soon as any high-order coefficient crosses x^127. The directed x·x^127 case exposes this in one operation. A wrong capture or a wrong operand select shows when the inputs are disturbed after start or when `cipher_blk` is nonzero in plain mode, and `result` differs at the very next `done`.

// File: rtl/ghash_pkg.sv
package ghash_pkg;
  localparam int unsigned GF_W = 128;
  typedef logic [GF_W-1:0] gf_t;

  // Reduction constant: x^128 = x^7 + x^2 + x + 1, expressed in reflected order
  localparam gf_t GF_RED = {8'hE1, 120'h0};

  // Multiply a field element by x (one step toward higher powers)
  function automatic gf_t gf_times_x(input gf_t v);
    gf_t shifted;
    shifted = v >> 1;
    if (v[0]) shifted = shifted ^ GF_RED;
    return shifted;
  endfunction

  // One multiply iteration: conditionally add the multiplicand to the sum
  function automatic gf_t gf_add_term(input gf_t sum, input gf_t mcand, input logic take);
    return take ? (sum ^ mcand) : sum;
  endfunction
endpackage

// File: rtl/ghash_operand_sel.sv
module ghash_operand_sel #(
  parameter int ELEM_W = 32,
  parameter int ELEMS  = 4
) (
  input  logic                      accumulate,
  input  logic [ELEM_W*ELEMS-1:0]   prev_hash,
  input  logic [ELEM_W*ELEMS-1:0]   cipher_blk,
  output logic [ELEM_W*ELEMS-1:0]   operand
);
  for (genvar e = 0; e < ELEMS; e++) begin : g_elem
    logic [ELEM_W-1:0] fold;
    assign fold = accumulate ? cipher_blk[e*ELEM_W +: ELEM_W] : '0;
    assign operand[e*ELEM_W +: ELEM_W] = prev_hash[e*ELEM_W +: ELEM_W] ^ fold;
  end
endmodule

// File: rtl/ghash_sequencer.sv
module ghash_sequencer #(
  parameter int W = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic accept,
  output logic step,
  output logic last,
  output logic done
);
  localparam int CNT_W = $clog2(W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(W - 1);

  logic             busy;
  logic [CNT_W-1:0] cnt;

  assign accept = start && !busy;
  assign step   = busy;
  assign last   = busy && (cnt == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= last;
      if (accept) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
        if (last) busy <= 1'b0;
      end
    end
  end

  // R5: done follows the final iteration on the next edge
  a_r5_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> done);
  // R5: done never appears without a preceding busy cycle
  a_r5_done_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  // R6: done is a single-cycle pulse
  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: start during an operation neither restarts nor stalls the count
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last) |=> (busy && cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/ghash_datapath.sv
module ghash_datapath
  import ghash_pkg::*;
#(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  logic         step,
  input  logic         last,
  input  logic [W-1:0] operand,
  input  logic [W-1:0] hash_key,
  output logic [W-1:0] mult_q,
  output logic [W-1:0] result
);
  gf_t mcand_q;
  gf_t sum_q;
  gf_t sum_next;

  assign sum_next = gf_add_term(sum_q, mcand_q, mult_q[W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_q  <= '0;
      mcand_q <= '0;
      sum_q   <= '0;
      result  <= '0;
    end else if (accept) begin
      mult_q  <= operand;
      mcand_q <= hash_key;
      sum_q   <= '0;
    end else if (step) begin
      mult_q  <= mult_q << 1;
      mcand_q <= gf_times_x(mcand_q);
      sum_q   <= sum_next;
      if (last) result <= sum_next;
    end
  end

  // R6: result only moves on the final iteration
  a_r6_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(result));
  // R9: a zero multiplier leaves the running sum untouched
  a_r9_zero_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !last && mult_q == '0 && sum_q == '0) |=> (sum_q == '0));
endmodule

// File: rtl/ghash_mul_unit.sv
module ghash_mul_unit #(
  parameter int ELEM_W = 32,
  parameter int ELEMS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    accumulate,
  input  logic [ELEM_W*ELEMS-1:0] prev_hash,
  input  logic [ELEM_W*ELEMS-1:0] cipher_blk,
  input  logic [ELEM_W*ELEMS-1:0] hash_key,
  output logic [ELEM_W*ELEMS-1:0] result,
  output logic                    done
);
  localparam int W = ELEM_W * ELEMS;

  logic         accept;
  logic         step;
  logic         last;
  logic [W-1:0] operand;
  logic [W-1:0] mult_q;

  ghash_operand_sel #(.ELEM_W(ELEM_W), .ELEMS(ELEMS)) u_sel (
    .accumulate (accumulate),
    .prev_hash  (prev_hash),
    .cipher_blk (cipher_blk),
    .operand    (operand)
  );

  ghash_sequencer #(.W(W)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .accept (accept),
    .step   (step),
    .last   (last),
    .done   (done)
  );

  ghash_datapath #(.W(W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .step     (step),
    .last     (last),
    .operand  (operand),
    .hash_key (hash_key),
    .mult_q   (mult_q),
    .result   (result)
  );

  // R2: plain multiply captures the operand untouched by the ciphertext
  a_r2_plain_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !accumulate) |=> (mult_q == $past(prev_hash)));
  // R3: accumulate form captures the XOR of hash and ciphertext
  a_r3_fold_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && accumulate) |=> (mult_q == ($past(prev_hash) ^ $past(cipher_blk))));
endmodule

// File: tb/ghash_mul_unit_test.sv
`timescale 1ns/1ps
module ghash_mul_unit_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         accumulate = 1'b0;
  logic [127:0] prev_hash = '0;
  logic [127:0] cipher_blk = '0;
  logic [127:0] hash_key = '0;
  logic [127:0] result;
  logic         done;

  always #2 clk = ~clk;

  ghash_mul_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .accumulate(accumulate),
    .prev_hash(prev_hash), .cipher_blk(cipher_blk), .hash_key(hash_key),
    .result(result), .done(done)
  );

  typedef struct {
    logic [127:0] value;
    int           due;
    string        tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  bit   finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Independent model: plain polynomial order, full product then fold
  function automatic logic [127:0] rev128(input logic [127:0] a);
    logic [127:0] r;
    for (int i = 0; i < 128; i++) r[i] = a[127-i];
    return r;
  endfunction

  function automatic logic [127:0] ref_mul(input logic [127:0] a, input logic [127:0] b);
    logic [127:0] ar, br;
    logic [255:0] p;
    ar = rev128(a);
    br = rev128(b);
    p = '0;
    for (int i = 0; i < 128; i++)
      if (ar[i]) p = p ^ ({128'h0, br} << i);
    for (int k = 254; k >= 128; k--)
      if (p[k]) begin
        p[k] = 1'b0;
        p[k-121] = ~p[k-121];
        p[k-126] = ~p[k-126];
        p[k-127] = ~p[k-127];
        p[k-128] = ~p[k-128];
      end
    return rev128(p[127:0]);
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: issues one operation, disturbs inputs afterwards (R8),
  // optionally pokes start while busy (R7)
  task automatic run_op(input logic acc, input logic [127:0] a, input logic [127:0] c,
                        input logic [127:0] h, input string tag, input bit poke);
    exp_t e;
    wait (q.size() == 0);
    @(negedge clk);
    @(negedge clk);
    accumulate = acc; prev_hash = a; cipher_blk = c; hash_key = h; start = 1'b1;
    e.value = acc ? ref_mul(a ^ c, h) : ref_mul(a, h);
    e.due   = cyc + 129;
    e.tag   = tag;
    q.push_back(e);
    @(negedge clk);
    start = 1'b0;
    accumulate = ~acc; prev_hash = rnd128(); cipher_blk = rnd128(); hash_key = rnd128();
    if (poke) begin
      repeat (50) @(negedge clk);
      prev_hash = rnd128(); hash_key = rnd128(); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
  endtask

  // Monitor: compares results, timing, pulse width and hold
  logic [127:0] held = '0;
  bit           prev_done = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done) begin
        if (prev_done) begin
          errors++; checks++;
          $display("FAIL R6 done high two cycles actual=1 expected=0");
        end else if (q.size() == 0) begin
          errors++; checks++;
          $display("FAIL R7 unexpected done actual=1 expected=0");
        end else begin
          exp_t e;
          e = q.pop_front();
          check(e.tag, result, e.value);
          checks++;
          if (cyc != e.due) begin
            errors++;
            $display("FAIL R5 done cycle actual=%0d expected=%0d", cyc, e.due);
          end
        end
        held = result;
      end else begin
        if (result !== held) begin
          errors++; checks++;
          $display("FAIL R6 result moved actual=%h expected=%h", result, held);
          held = result;
        end
        if (q.size() != 0 && cyc > q[0].due) begin
          errors++; checks++;
          $display("FAIL R5 done missing actual=%0d expected=%0d", cyc, q[0].due);
          void'(q.pop_front());
        end
      end
      prev_done = done;
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] one_x0;
    one_x0 = {1'b1, 127'h0};
    repeat (3) @(negedge clk);
    check("R1 result after reset", result, '0);
    check("R1 done after reset", {127'h0, done}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 reduction: x^1 * x^127 = x^7+x^2+x+1
    run_op(1'b0, {1'b0, 1'b1, 126'h0}, '0, {127'h0, 1'b1}, "R4 wraparound", 0);
    wait (q.size() == 0);
    check("R4 literal", held, {8'hE1, 120'h0});
    // R4 identity
    run_op(1'b0, one_x0, '0, 128'h0123456789ABCDEF_FEDCBA9876543210, "R4 identity", 0);
    wait (q.size() == 0);
    check("R4 identity literal", held, 128'h0123456789ABCDEF_FEDCBA9876543210);
    // R2 plain multiply, ciphertext present but ignored
    for (int i = 0; i < 4; i++)
      run_op(1'b0, rnd128(), rnd128(), rnd128(), "R2 plain multiply", 0);
    // R3 accumulate-multiply
    for (int i = 0; i < 4; i++)
      run_op(1'b1, rnd128(), rnd128(), rnd128(), "R3 accumulate multiply", 0);
    // R9 zero key and zero folded multiplier
    run_op(1'b0, rnd128(), '0, '0, "R9 zero key", 0);
    begin
      logic [127:0] v;
      v = rnd128();
      run_op(1'b1, v, v, rnd128(), "R9 zero fold", 0);
    end
    // R5 extreme data patterns give the same latency
    run_op(1'b0, '1, '0, '1, "R5 all ones", 0);
    // R7 start pulse while busy is ignored; R8 disturbed inputs
    run_op(1'b1, rnd128(), rnd128(), rnd128(), "R7 busy start ignored", 1);
    run_op(1'b0, rnd128(), rnd128(), rnd128(), "R8 capture at start", 1);
    wait (q.size() == 0);
    repeat (5) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule